// File: doc/BRIEF.md
# Virtual Segment Identifier Scrambler

This unit turns a process context number and an effective address into a scrambled virtual segment identifier (VSID) for a hashed page table. It first joins the context and the effective segment number into a proto-identifier. It then multiplies that value by the 24-bit prime 12538073. Finally it reduces the product modulo 2^n − 1 without a divider. The reduction folds the high part of the product onto the low part, then applies an end-around carry correction.

Two segment sizes are supported: short segments of 2^28 bytes and long segments of 2^40 bytes. A kernel flag replaces the caller's context with one of the four top contexts, selected by the address region nibble. An address that lies beyond a programmable table-range limit yields VSID 0. A request enters on any cycle and its result leaves three cycles later, so one request can be issued per cycle.

Top module: `vsid_scramble_unit`

## Requirements
- R1: With seg_1t_i low, the proto-identifier is {ctx, ea_i[45:28]} (37 bits), and the modulus is 2^37 − 1.
- R2: With seg_1t_i high, the proto-identifier is {ctx, ea_i[45:40]} (25 bits) and the modulus is 2^25 − 1. vsid_o[36:25] is then zero.
- R3: vsid_o equals (proto × 12538073) mod (2^n − 1) and always lies in 0 .. 2^n − 2. A proto of 0 yields 0, and a proto of 2^n − 1 yields 0.
- R4: When {4'h0, ea_i[59:0]} >= range_limit_i, vsid_o is 0.
- R5: With kernel_i high and region nibble ea_i[63:60] in 0xC..0xF, ctx = 0x7FFFC + (nibble − 0xC), and ctx_i is ignored. Otherwise ctx = ctx_i.
- R6: With kernel_i high and a region nibble below 0xC, vsid_o is 0 and kern_err_o is 1 in the result cycle. kern_err_o is 0 in every other case.
- R7: A request sampled with req_valid_i high at clock edge k appears with vsid_valid_o high after edge k+3. A request can be accepted on every cycle, and vsid_valid_o follows req_valid_i delayed by three cycles.
- R8: While reset is held and after its release, before any request, vsid_valid_o, kern_err_o and vsid_o are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_valid_i | input | 1 | Request strobe |
| ctx_i | input | 19 | Process context number |
| ea_i | input | 64 | Effective address |
| seg_1t_i | input | 1 | 1 selects long (2^40 byte) segments |
| kernel_i | input | 1 | Derive the context from the region nibble |
| range_limit_i | input | 64 | Exclusive upper bound on the region-cleared address |
| vsid_valid_o | output | 1 | Result strobe |
| vsid_o | output | 37 | Scrambled segment identifier |
| kern_err_o | output | 1 | Kernel request with an illegal region nibble |

## Verification
The bench drives a proto-identifier of 2^n − 2, which a reduction without the final carry correction still gets right. It also drives the all-ones proto, where the fold lands exactly on the modulus, so a missing correction would return 2^n − 1 instead of 0. Both cases are run for both segment sizes, together with proto 0 and random values against a direct multiply-then-modulo model. The range limit is hit at equality and one below, which exposes an off-by-one in the comparison. Kernel requests at nibbles 0xB, 0xC and 0xF expose a wrong context base or an unflagged illegal region. Requests with and without idle gaps show whether a valid flag slips away from its data.

// File: rtl/vsid_pkg.sv
package vsid_pkg;
  parameter int CTX_W     = 19;
  parameter int EA_W      = 64;
  parameter int REG_W     = 4;
  parameter int MULT_W    = 24;
  parameter int SEG_SH_S  = 28;
  parameter int SEG_SH_L  = 40;
  parameter int ESID_W_S  = 18;
  parameter int ESID_W_L  = 6;
  parameter int N_S       = CTX_W + ESID_W_S;
  parameter int N_L       = CTX_W + ESID_W_L;
  parameter int PROD_W    = N_S + MULT_W;
  parameter logic [MULT_W-1:0] MULT = 24'd12538073;
  parameter logic [REG_W-1:0]  KERN_NIB0 = 4'hC;
endpackage

// File: rtl/vsid_proto_gen.sv
module vsid_proto_gen
  import vsid_pkg::*;
(
  input  logic [CTX_W-1:0] ctx_i,
  input  logic [EA_W-1:0]  ea_i,
  input  logic             seg_1t_i,
  input  logic             kernel_i,
  input  logic [EA_W-1:0]  range_limit_i,
  output logic [N_S-1:0]   proto_o,
  output logic             kerr_o
);
  localparam logic [CTX_W-1:0] KERN_CTX0 = CTX_W'((1 << CTX_W) - 4);

  logic [REG_W-1:0] nib;
  logic [CTX_W-1:0] ctx_eff;
  logic [EA_W-1:0]  ea_clr;
  logic             over, kill;
  logic [N_S-1:0]   proto_s, proto_l;

  assign nib     = ea_i[EA_W-1 -: REG_W];
  assign kerr_o  = kernel_i && (nib < KERN_NIB0);
  assign ctx_eff = kernel_i ? KERN_CTX0 + CTX_W'(nib - KERN_NIB0) : ctx_i;
  assign ea_clr  = {{REG_W{1'b0}}, ea_i[EA_W-REG_W-1:0]};
  assign over    = ea_clr >= range_limit_i;
  assign kill    = kerr_o || over;

  assign proto_s = {ctx_eff, ea_i[SEG_SH_S +: ESID_W_S]};
  assign proto_l = N_S'({ctx_eff, ea_i[SEG_SH_L +: ESID_W_L]});

  // zero proto scrambles to zero
  assign proto_o = kill ? '0 : (seg_1t_i ? proto_l : proto_s);
endmodule

// File: rtl/vsid_mul_stage.sv
module vsid_mul_stage
  import vsid_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              vld_i,
  input  logic [N_S-1:0]    proto_i,
  input  logic              sel_lo_i,
  input  logic              err_i,
  output logic              vld_o,
  output logic [PROD_W-1:0] prod_o,
  output logic              sel_lo_o,
  output logic              err_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_o    <= 1'b0;
      prod_o   <= '0;
      sel_lo_o <= 1'b0;
      err_o    <= 1'b0;
    end else begin
      vld_o    <= vld_i;
      prod_o   <= PROD_W'(proto_i) * PROD_W'(MULT);
      sel_lo_o <= sel_lo_i;
      err_o    <= err_i;
    end
  end
endmodule

// File: rtl/vsid_mod_reduce.sv
module vsid_mod_reduce
  import vsid_pkg::*;
#(
  parameter int N_HI = N_S,
  parameter int N_LO = N_L,
  parameter int PW   = PROD_W,
  parameter int MW   = MULT_W
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            vld_i,
  input  logic [PW-1:0]   prod_i,
  input  logic            sel_lo_i,
  input  logic            err_i,
  output logic            vld_o,
  output logic [N_HI-1:0] res_o,
  output logic            sel_lo_o,
  output logic            err_o
);
  localparam int XW = N_HI + 1;
  localparam logic [XW-1:0]   FOLD_MAX_HI = (XW'(1) << N_HI) + (XW'(1) << MW);
  localparam logic [XW-1:0]   FOLD_MAX_LO = (XW'(1) << N_LO) + (XW'(1) << MW);
  localparam logic [N_HI-1:0] MOD_HI = {N_HI{1'b1}};
  localparam logic [N_HI-1:0] MOD_LO = N_HI'({N_LO{1'b1}});

  logic [1:0][XW-1:0]   fold_c;
  logic [1:0][N_HI-1:0] corr_c;
  logic [XW-1:0]        x_q;
  logic                 vld_q, sel_q, err_q;

  for (genvar g = 0; g < 2; g++) begin : g_lane
    localparam int NW = (g == 0) ? N_HI : N_LO;
    logic [XW-1:0] xp1, carry, sum;
    // end-around fold of the high part onto the low part
    assign fold_c[g] = XW'(prod_i >> NW) + XW'(prod_i[NW-1:0]);
    // add one more when x reaches the modulus or beyond
    assign xp1       = x_q + XW'(1);
    assign carry     = xp1 >> NW;
    assign sum       = x_q + carry;
    assign corr_c[g] = N_HI'(sum[NW-1:0]);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q <= 1'b0;
      x_q   <= '0;
      sel_q <= 1'b0;
      err_q <= 1'b0;
    end else begin
      vld_q <= vld_i;
      x_q   <= sel_lo_i ? fold_c[1] : fold_c[0];
      sel_q <= sel_lo_i;
      err_q <= err_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_o    <= 1'b0;
      res_o    <= '0;
      sel_lo_o <= 1'b0;
      err_o    <= 1'b0;
    end else begin
      vld_o    <= vld_q;
      res_o    <= sel_q ? corr_c[1] : corr_c[0];
      sel_lo_o <= sel_q;
      err_o    <= err_q;
    end
  end

  assert_fold_bound_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vld_q |-> (x_q < (sel_q ? FOLD_MAX_LO : FOLD_MAX_HI)));

  assert_residue_range_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vld_o |-> (res_o < (sel_lo_o ? MOD_LO : MOD_HI)));

  assert_long_seg_width_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vld_o && sel_lo_o) |-> (res_o[N_HI-1:N_LO] == '0));
endmodule

// File: rtl/vsid_scramble_unit.sv
module vsid_scramble_unit
  import vsid_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_valid_i,
  input  logic [CTX_W-1:0] ctx_i,
  input  logic [EA_W-1:0]  ea_i,
  input  logic             seg_1t_i,
  input  logic             kernel_i,
  input  logic [EA_W-1:0]  range_limit_i,
  output logic             vsid_valid_o,
  output logic [N_S-1:0]   vsid_o,
  output logic             kern_err_o
);
  logic [N_S-1:0]    proto;
  logic              kerr;
  logic              m_vld, m_sel, m_err;
  logic [PROD_W-1:0] m_prod;
  logic              r_vld, r_sel, r_err;
  logic [N_S-1:0]    r_res;

  vsid_proto_gen u_proto (
    .ctx_i         (ctx_i),
    .ea_i          (ea_i),
    .seg_1t_i      (seg_1t_i),
    .kernel_i      (kernel_i),
    .range_limit_i (range_limit_i),
    .proto_o       (proto),
    .kerr_o        (kerr)
  );

  vsid_mul_stage u_mul (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .vld_i    (req_valid_i),
    .proto_i  (proto),
    .sel_lo_i (seg_1t_i),
    .err_i    (kerr),
    .vld_o    (m_vld),
    .prod_o   (m_prod),
    .sel_lo_o (m_sel),
    .err_o    (m_err)
  );

  vsid_mod_reduce u_reduce (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .vld_i    (m_vld),
    .prod_i   (m_prod),
    .sel_lo_i (m_sel),
    .err_i    (m_err),
    .vld_o    (r_vld),
    .res_o    (r_res),
    .sel_lo_o (r_sel),
    .err_o    (r_err)
  );

  assign vsid_valid_o = r_vld;
  assign vsid_o       = r_res;
  assign kern_err_o   = r_vld && r_err;

  assert_kern_err_zero_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    kern_err_o |-> (vsid_o == '0));

  assert_latency_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vsid_valid_o |-> $past(req_valid_i, 3));

  assert_err_qualified_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !vsid_valid_o |-> !kern_err_o);

  assert_long_seg_out_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vsid_valid_o && r_sel) |-> (vsid_o[N_S-1:N_L] == '0));
endmodule

// File: tb/vsid_scramble_unit_bench.sv
module vsid_scramble_unit_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [18:0] ctx = '0;
  logic [63:0] ea = '0;
  logic        seg_1t = 1'b0;
  logic        kernel = 1'b0;
  logic [63:0] lim = '1;
  logic        vsid_valid;
  logic [36:0] vsid;
  logic        kern_err;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  bit               q_v[$];
  longint unsigned  q_vsid[$];
  bit               q_err[$];
  string            q_tag[$];

  always #10 clk = ~clk;

  vsid_scramble_unit u_vsid_scramble_unit (
    .clk_i         (clk),
    .rst_ni        (rst_n),
    .req_valid_i   (req_valid),
    .ctx_i         (ctx),
    .ea_i          (ea),
    .seg_1t_i      (seg_1t),
    .kernel_i      (kernel),
    .range_limit_i (lim),
    .vsid_valid_o  (vsid_valid),
    .vsid_o        (vsid),
    .kern_err_o    (kern_err)
  );

  function automatic longint unsigned model(input logic [18:0] c, input logic [63:0] a,
                                            input bit s1t, input bit kern,
                                            input logic [63:0] l, output bit err);
    longint unsigned cc, esid, proto, m;
    int n;
    logic [3:0] nib;
    nib = a[63:60];
    err = kern && (nib < 4'hC);
    cc  = c;
    if (kern && !err) cc = 64'h7FFFC + (nib - 4'hC);
    if (err || ({4'h0, a[59:0]} >= l)) return 0;
    n = s1t ? 25 : 37;
    esid = s1t ? (a >> 40) & 64'h3F : (a >> 28) & 64'h3FFFF;
    proto = (cc << (n - 19)) | esid;
    m = (64'd1 << n) - 1;
    return (proto * 64'd12538073) % m;
  endfunction

  task automatic check_out();
    bit ev, ee;
    longint unsigned exv;
    string tg;
    if (q_v.size() == 0) return;
    ev = q_v.pop_front(); exv = q_vsid.pop_front(); ee = q_err.pop_front(); tg = q_tag.pop_front();
    n_chk++;
    if (vsid_valid !== ev) begin
      n_bad++;
      $display("FAIL %s/R7 valid got %0b exp %0b", tg, vsid_valid, ev);
    end else if (ev && (vsid !== exv[36:0] || kern_err !== ee)) begin
      n_bad++;
      $display("FAIL %s vsid got %h/%0b exp %h/%0b", tg, vsid, kern_err, exv[36:0], ee);
    end else if (!ev && kern_err !== 1'b0) begin
      n_bad++;
      $display("FAIL R6 idle kern_err got %0b exp 0", kern_err);
    end
  endtask

  task automatic step(input bit v, input logic [18:0] c, input logic [63:0] a,
                      input bit s1t, input bit kern, input logic [63:0] l, input string tg);
    bit e;
    longint unsigned r;
    @(negedge clk);
    check_out();
    req_valid = v; ctx = c; ea = a; seg_1t = s1t; kernel = kern; lim = l;
    r = model(c, a, s1t, kern, l, e);
    q_v.push_back(v); q_vsid.push_back(r); q_err.push_back(e); q_tag.push_back(tg);
  endtask

  task automatic idle();
    step(1'b0, '0, '0, 1'b0, 1'b0, '1, "R7");
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    // R8: outputs quiet during reset
    n_chk++;
    if (vsid_valid !== 1'b0 || kern_err !== 1'b0 || vsid !== '0) begin
      n_bad++;
      $display("FAIL R8 reset got %0b/%0b/%h exp 0/0/0", vsid_valid, kern_err, vsid);
    end
    @(negedge clk);
    rst_n = 1'b1;
    for (int i = 0; i < 3; i++) begin
      q_v.push_back(1'b0); q_vsid.push_back(0); q_err.push_back(1'b0); q_tag.push_back("R8");
    end

    // R3 corner protos, short segments (R1)
    step(1'b1, 19'h0,     64'h0,                       1'b0, 1'b0, '1, "R3");
    step(1'b1, 19'h7FFFF, 64'h0000_3FFF_E000_0000,     1'b0, 1'b0, '1, "R3");
    step(1'b1, 19'h7FFFF, 64'h0000_3FFF_F000_0000,     1'b0, 1'b0, '1, "R3");
    step(1'b1, 19'h12345, 64'h0000_2ABC_D000_0000,     1'b0, 1'b0, '1, "R1");
    // long segments (R2)
    step(1'b1, 19'h7FFFF, 64'h0000_3E00_0000_0000,     1'b1, 1'b0, '1, "R3");
    step(1'b1, 19'h7FFFF, 64'h0000_3F00_0000_0000,     1'b1, 1'b0, '1, "R3");
    step(1'b1, 19'h0,     64'h0,                       1'b1, 1'b0, '1, "R2");
    step(1'b1, 19'h54321, 64'h0000_1500_0000_0000,     1'b1, 1'b0, '1, "R2");
    idle();
    // R4 range limit at equality and just below
    step(1'b1, 19'h00011, 64'h0000_4000_0000_0000,     1'b0, 1'b0, 64'h0000_4000_0000_0000, "R4");
    step(1'b1, 19'h00011, 64'h0000_3FFF_FFFF_FFFF,     1'b0, 1'b0, 64'h0000_4000_0000_0000, "R4");
    step(1'b1, 19'h00011, 64'h7000_1000_0000_0000,     1'b0, 1'b0, 64'h0000_4000_0000_0000, "R4");
    idle(); idle();
    // R5 / R6 kernel contexts
    step(1'b1, 19'h01234, 64'hC000_0000_1000_0000,     1'b0, 1'b1, '1, "R5");
    step(1'b1, 19'h7FFFF, 64'hF000_0123_4000_0000,     1'b0, 1'b1, '1, "R5");
    step(1'b1, 19'h00000, 64'hD000_0100_0000_0000,     1'b1, 1'b1, '1, "R5");
    step(1'b1, 19'h01234, 64'hB000_0000_1000_0000,     1'b0, 1'b1, '1, "R6");
    step(1'b1, 19'h01234, 64'h0000_0000_1000_0000,     1'b1, 1'b1, '1, "R6");

    // random mix with gaps (R7)
    for (int i = 0; i < 400; i++) begin
      logic [18:0] rc;
      logic [63:0] ra, rl;
      bit rs, rk, rv, e;
      longint unsigned dummy;
      string tg;
      rc = 19'($urandom);
      ra = {$urandom, $urandom};
      if ($urandom % 2 == 0) ra[59:46] = '0;
      rs = $urandom % 2;
      rk = ($urandom % 4) == 0;
      rv = ($urandom % 4) != 0;
      rl = (($urandom % 5) == 0) ? ({$urandom, $urandom} >> 4) : 64'hFFFF_FFFF_FFFF_FFFF;
      dummy = model(rc, ra, rs, rk, rl, e);
      if (e) tg = "R6";
      else if ({4'h0, ra[59:0]} >= rl) tg = "R4";
      else if (rk) tg = "R5";
      else tg = rs ? "R2" : "R1";
      step(rv, rc, ra, rs, rk, rl, tg);
    end
    repeat (4) idle();
    @(negedge clk);
    check_out();

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule